// File: doc/BRIEF.md
# SPI Receive Queue with Exported Pop Index

This block buffers frames received by an SPI shift register. When the serial side signals that a frame is complete, the shift-register word is copied into a four-entry circular store. Software removes frames in arrival order by reading a pop register. The only other way to discard frames is a flush. The serial receiver and the bus decoder are outside the block. They appear here as a frame-done strobe with its data word, and as single-cycle read, flush and clear strobes.

Two status fields are exported. The first is the number of valid entries. The second is the slot index that the next pop will return, counted from slot 0. Any slot can also be read by index without disturbing the queue, so software can inspect the raw storage. A frame that arrives when no slot can take it is dropped, and a sticky overflow flag records the loss. Software clears the flag by writing one to it.

Top module: `spi_rx_queue`

## Requirements
- R1: A `frame_done_i` pulse with fewer than 4 valid entries stores `frame_data_i` in the slot after the newest entry. `count_o` is one higher after that clock edge.
- R2: While `pop_rd_i` is high and the queue is non-empty, `pop_data_o` combinationally shows the oldest entry. At the clock edge that entry is removed, `count_o` falls by one, and `pop_ptr_o` advances by one, wrapping from 3 to 0.
- R3: `count_o` always equals the number of valid entries and never exceeds 4.
- R4: `pop_ptr_o` is the slot index, from 0 to 3, of the entry that the next pop returns.
- R5: A pop on an empty queue returns the slot at `pop_ptr_o`, and `count_o` and `pop_ptr_o` do not change.
- R6: A `frame_done_i` pulse with 4 valid entries and no accepted pop in the same cycle is discarded. Storage and `count_o` are unchanged, and `ovf_o` goes to 1.
- R7: `ovf_o` stays at 1 until a cycle with `ovf_clr_i` high and no new overflow event. If both occur in the same cycle, the flag stays set.
- R8: `flush_i` sets `count_o` to 0 and both the pop and write positions to slot 0 at the next edge. A frame or pop arriving in the same cycle is ignored. The next stored frame lands in slot 0.
- R9: A pop and a frame in the same cycle on a non-empty queue leave `count_o` unchanged. This holds even when the queue is full, in which case the new frame is kept.
- R10: `peek_data_o` shows the slot selected by `peek_idx_i`, and reading it changes no state.
- R11: After reset, `count_o` is 0, `pop_ptr_o` is 0 and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_done_i | input | 1 | Frame-complete strobe from the shift register |
| frame_data_i | input | 32 | Received frame word |
| pop_rd_i | input | 1 | Pop-register read strobe |
| pop_data_o | output | 32 | Data returned by a pop read |
| flush_i | input | 1 | Empty the queue |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| ovf_o | output | 1 | Sticky overflow flag |
| count_o | output | 3 | Number of valid entries |
| pop_ptr_o | output | 2 | Slot index of the next pop |
| peek_idx_i | input | 2 | Slot index for the non-destructive read |
| peek_data_o | output | 32 | Contents of the selected slot |

## Verification
The critical coincidence is a frame arriving in the same cycle as a pop read. The bench drives both strobes together in three states: a mid-level queue, an empty queue (only the frame is taken) and a full queue (the pop frees the slot the frame takes). A scoreboard queue of expected words judges every case, with the count and pointer checked after the edge. Flush is also raised together with both strobes, and the bench expects it to win. A clear arriving with an overflow event is checked to leave the flag set.

// File: rtl/spi_rxq_pkg.sv
package spi_rxq_pkg;
  // Decision taken by the control logic for one cycle
  typedef struct packed {
    logic push_ok;  // frame accepted into storage
    logic pop_ok;   // oldest entry released
    logic drop;     // frame lost because no slot is free
  } rxq_op_t;
endpackage

// File: rtl/rxq_storage.sv
module rxq_storage #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  pop_idx_i,
  output logic [DATA_W-1:0] pop_data_o,
  input  logic [PTR_W-1:0]  peek_idx_i,
  output logic [DATA_W-1:0] peek_data_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = we_i && (wr_idx_i == PTR_W'(g));
    always_ff @(posedge clk_i) begin
      if (slot_en) slot_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    pop_data_o  = slot_q[pop_idx_i];
    peek_data_o = slot_q[peek_idx_i];
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import spi_rxq_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_done_i,
  input  logic             pop_rd_i,
  input  logic             flush_i,
  output rxq_op_t          op_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;
  logic             is_empty, is_full;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    is_empty       = (cnt_q == '0);
    is_full        = (cnt_q == FULL_CNT);
    op_o.pop_ok    = pop_rd_i && !is_empty && !flush_i;
    op_o.push_ok   = frame_done_i && !flush_i && (!is_full || op_o.pop_ok);
    op_o.drop      = frame_done_i && !flush_i && is_full && !op_o.pop_ok;
  end

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    cnt_d  = cnt_q;
    upd_en = flush_i || op_o.push_ok || op_o.pop_ok;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (op_o.push_ok) wr_d = step_ptr(wr_q);
      if (op_o.pop_ok)  rd_d = step_ptr(rd_q);
      unique case ({op_o.push_ok, op_o.pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign count_o  = cnt_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT); // R3
  AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_rd_i && !is_empty && !flush_i) |=> rd_q == step_ptr($past(rd_q))); // R2
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_rd_i && is_empty && !frame_done_i && !flush_i) |=> $stable(rd_q) && cnt_q == '0); // R5
  AST_BOTH_KEEP_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_rd_i && frame_done_i && !is_empty && !flush_i) |=> $stable(cnt_q)); // R9
  AST_FLUSH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0 && rd_q == '0 && wr_q == '0)); // R8
endmodule

// File: rtl/rxq_ovf.sv
module rxq_ovf (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i || clr_i;
    flag_d  = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R7
  AST_OVF_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q); // R7
endmodule

// File: rtl/spi_rx_queue.sv
module spi_rx_queue
  import spi_rxq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              pop_rd_i,
  output logic [DATA_W-1:0] pop_data_o,
  input  logic              flush_i,
  input  logic              ovf_clr_i,
  output logic              ovf_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [PTR_W-1:0]  pop_ptr_o,
  input  logic [PTR_W-1:0]  peek_idx_i,
  output logic [DATA_W-1:0] peek_data_o
);
  rxq_op_t          op;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_done_i(frame_done_i),
    .pop_rd_i    (pop_rd_i),
    .flush_i     (flush_i),
    .op_o        (op),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .count_o     (count_o)
  );

  rxq_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .we_i       (op.push_ok),
    .wr_idx_i   (wr_ptr),
    .wr_data_i  (frame_data_i),
    .pop_idx_i  (rd_ptr),
    .pop_data_o (pop_data_o),
    .peek_idx_i (peek_idx_i),
    .peek_data_o(peek_data_o)
  );

  rxq_ovf u_ovf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (op.drop),
    .clr_i (ovf_clr_i),
    .flag_o(ovf_o)
  );

  assign pop_ptr_o = rd_ptr;

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && count_o == CNT_W'(DEPTH) && !pop_rd_i && !flush_i)
      |=> ovf_o && count_o == CNT_W'(DEPTH)); // R6
  AST_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && count_o < CNT_W'(DEPTH) && !pop_rd_i && !flush_i)
      |=> count_o == $past(count_o) + 1'b1); // R1
  AST_PEEK_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_done_i && !pop_rd_i && !flush_i) |=> $stable(count_o) && $stable(pop_ptr_o)); // R10
endmodule

// File: tb/test_spi_rx_queue.sv
module test_spi_rx_queue;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        frame_done_i, pop_rd_i, flush_i, ovf_clr_i;
  logic [31:0] frame_data_i, pop_data_o, peek_data_o;
  logic        ovf_o;
  logic [2:0]  count_o;
  logic [1:0]  pop_ptr_o, peek_idx_i;

  spi_rx_queue i_spi_rx_queue (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_done_i(frame_done_i),
    .frame_data_i(frame_data_i), .pop_rd_i(pop_rd_i), .pop_data_o(pop_data_o),
    .flush_i(flush_i), .ovf_clr_i(ovf_clr_i), .ovf_o(ovf_o), .count_o(count_o),
    .pop_ptr_o(pop_ptr_o), .peek_idx_i(peek_idx_i), .peek_data_o(peek_data_o)
  );

  always #2 clk_i = ~clk_i;  // 250 MHz

  int          n_cmp = 0, n_bad = 0;
  bit          finished = 0;
  logic [31:0] sb[$];
  logic [31:0] shadow [4];
  int          exp_rd = 0, exp_wr = 0;
  logic        exp_ovf = 1'b0;
  logic        mon_pop = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compares every accepted pop against the scoreboard head
  always @(negedge clk_i) begin
    #1;
    if (mon_pop) begin
      logic [31:0] head;
      head = sb.pop_front();
      check("R2 pop returns oldest entry", pop_data_o, head);
    end
  end

  task automatic status(input string req);
    check({req, " count"}, 32'(count_o), 32'(sb.size()));
    check({req, " pop pointer (R4)"}, 32'(pop_ptr_o), 32'(exp_rd));
    check({req, " overflow flag"}, 32'(ovf_o), 32'(exp_ovf));
  endtask

  // Driver: one clock of stimulus plus model update
  task automatic step(input string req, input logic psh, input logic [31:0] d,
                      input logic pop, input logic fl, input logic clr);
    logic pa, pu, setv;
    @(negedge clk_i);
    frame_done_i = psh; frame_data_i = d; pop_rd_i = pop; flush_i = fl; ovf_clr_i = clr;
    pa = pop && (sb.size() > 0) && !fl;
    mon_pop = pa;
    #1;
    if (pop && sb.size() == 0 && !fl)
      check("R5 empty pop returns slot at pointer", pop_data_o, shadow[exp_rd]);
    @(posedge clk_i);
    #1;
    mon_pop = 1'b0;
    frame_done_i = 0; pop_rd_i = 0; flush_i = 0; ovf_clr_i = 0;
    setv = 1'b0;
    if (fl) begin
      sb.delete();
      exp_rd = 0; exp_wr = 0;
    end else begin
      pu = psh && (sb.size() < 4 || pa);
      if (pa) exp_rd = (exp_rd + 1) % 4;
      if (pu) begin
        shadow[exp_wr] = d;
        sb.push_back(d);
        exp_wr = (exp_wr + 1) % 4;
      end else if (psh) setv = 1'b1;
    end
    if (setv) exp_ovf = 1'b1;
    else if (clr) exp_ovf = 1'b0;
    status(req);
  endtask

  task automatic peek(input int idx);
    logic [2:0] c0;
    @(negedge clk_i);
    peek_idx_i = 2'(idx);
    c0 = count_o;
    #1;
    check("R10 peek slot contents", peek_data_o, shadow[idx]);
    @(posedge clk_i);
    #1;
    check("R10 peek leaves count", 32'(count_o), 32'(c0));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    frame_done_i = 0; frame_data_i = '0; pop_rd_i = 0; flush_i = 0;
    ovf_clr_i = 0; peek_idx_i = '0;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #1;
    status("R11 reset state");

    step("R1 push A", 1, 32'hA000_0001, 0, 0, 0);
    step("R1 push B", 1, 32'hB000_0002, 0, 0, 0);
    step("R1 push C", 1, 32'hC000_0003, 0, 0, 0);
    step("R2 pop", 0, 0, 1, 0, 0);
    step("R1 push D", 1, 32'hD000_0004, 0, 0, 0);
    step("R1 push E to full", 1, 32'hE000_0005, 0, 0, 0);
    step("R6 push while full dropped", 1, 32'hF000_0006, 0, 0, 0);
    for (int i = 0; i < 4; i++) peek(i);
    step("R9 push and pop while full", 1, 32'h1111_0007, 1, 0, 0);
    step("R7 clear with new overflow", 1, 32'h2222_0008, 0, 0, 1);
    step("R7 clear alone", 0, 0, 0, 0, 1);
    for (int i = 0; i < 4; i++) step("R2 drain with wrap", 0, 0, 1, 0, 0);
    step("R5 pop on empty", 0, 0, 1, 0, 0);
    step("R1 push H", 1, 32'h3333_0009, 0, 0, 0);
    step("R9 push and pop mid level", 1, 32'h4444_000A, 1, 0, 0);
    step("R2 pop", 0, 0, 1, 0, 0);
    step("R9 push and pop on empty", 1, 32'h5555_000B, 1, 0, 0);
    step("R1 push", 1, 32'h6666_000C, 0, 0, 0);
    step("R8 flush beats push and pop", 1, 32'h7777_000D, 1, 1, 0);
    step("R8 push after flush", 1, 32'h8888_000E, 0, 0, 0);
    peek(0);
    step("R2 pop after flush", 0, 0, 1, 0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule